// File: doc/BRIEF.md
# Five-Level Leg Redundant Switch-State Selector

This block drives one phase leg built from a three-level flying-capacitor cell in series with an H-bridge fed by a floating capacitor. Together the two stages give five pole levels. Once per sampling period, a one-cycle strobe presents four inputs: the requested pole level, the sign of the phase current, and a band status for each capacitor from external hysteresis comparators. Several levels can be built from more than one switch combination, and each combination moves the two capacitors in different directions. The block picks the combination that steers both capacitors back toward their nominal voltages. It registers the flying-capacitor cell state and the H-bridge state for the gate-timing logic downstream.

Each capacitor keeps a charge/discharge need. A below-band status sets the need to charge. An above-band status sets it to discharge. An in-band status keeps the previous need. When no single combination satisfies both capacitors, the flying capacitor wins if it is outside its band. If the flying capacitor is inside its band, the H-bridge capacitor is served instead and the flying capacitor is left idle. Level codes outside 0..4 leave the outputs unchanged and raise an error flag.

The active-low reset asserts asynchronously and is released through a two-stage synchronizer.

Top module: `fhs_balance_sel`

## Requirements
- R1: The reset state is: `fc_state` = 00, `hb_state` = 00, `level_err` = 0, and both capacitor needs set to charge. While the strobe is low, the outputs hold their reset values.
- R2: `fc_state`, `hb_state` and `level_err` change only in the cycle after a clock edge at which `sample_stb` is 1.
- R3: Level code 0 always gives `fc_state` = 00 (cell 0) and `hb_state` = 00 (bridge bypassed). Level code 4 always gives `fc_state` = 11 (cell full Vdc) and `hb_state` = 00. Both hold whatever the band statuses and the current sign are.
- R4: For valid codes 0..4, the chosen pair realizes the requested level, counted in Vdc/4 steps. `fc_state` contributes 00→0, 01→2, 10→2, 11→4. `hb_state` contributes 00→0, 01→+1, 10→−1. `hb_state` is never 11.
- R5: The band status is encoded 01 = below band, 10 = above band, 00 or 11 = in band. At each strobe, below band sets the need to charge, above band sets it to discharge, and in band keeps the previous need. The need used for a sample already includes that sample's status.
- R6: Level 2 bypasses the bridge. It uses mid state 01 when the flying-capacitor need equals `cur_pos`, and mid state 10 otherwise. Mid state 01 charges the flying capacitor when `cur_pos` = 1 and discharges it when `cur_pos` = 0; mid state 10 does the opposite.
- R7: At levels 1 and 3, the mid states pair with bridge −1 (level 1) or +1 (level 3). Bridge +1 charges its capacitor when `cur_pos` = 0; bridge −1 charges it when `cur_pos` = 1. When that paired bridge polarity meets the bridge need, the block picks the mid state that meets the flying-capacitor need.
- R8: At levels 1 and 3, when the paired polarity opposes the bridge need and the flying-capacitor status is below or above band, the mid state that meets the flying-capacitor need is still chosen.
- R9: At levels 1 and 3, when the paired polarity opposes the bridge need and the flying-capacitor status is in band, the edge combination is chosen: cell 00 with bridge +1 for level 1, or cell 11 with bridge −1 for level 3.
- R10: A strobe with level code 5, 6 or 7 holds `fc_state` and `hb_state` and sets `level_err`. The next strobe with a valid code clears `level_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle sampling strobe |
| level_req | input | 3 | Requested pole level code |
| cur_pos | input | 1 | Phase current sign, 1 = flowing out of the pole |
| fc_band | input | 2 | Flying-capacitor band status |
| hb_band | input | 2 | Bridge-capacitor band status |
| fc_state | output | 2 | Flying-capacitor cell state |
| hb_state | output | 2 | H-bridge state |
| level_err | output | 1 | Last strobe carried an invalid level code |

## Verification
The bench sweeps every level code against both current signs and all sixteen pairs of band statuses. Because the sweep order changes the held needs, in-band samples are tried against both remembered directions.

The expected combination is found by scoring every legal cell/bridge pair for the level, which is a different method from the RTL's decision chain. The sweep keeps separate the cases where both capacitors agree, where the flying capacitor's priority overrides the bridge, and where an in-band flying capacitor yields to the bridge.

A directed run walks the band status below → in → above → in at level 2 to show that the need is held. Further checks drive new inputs with the strobe low to show that the outputs hold, and feed invalid codes to show that the error flag is set and later cleared.

// File: rtl/fhs_pkg.sv
package fhs_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = 5;
  localparam int BAND_W  = 2;
  localparam int ST_W    = 2;

  localparam logic [ST_W-1:0] FC_ZERO = 2'b00;
  localparam logic [ST_W-1:0] FC_MIDA = 2'b01;
  localparam logic [ST_W-1:0] FC_MIDB = 2'b10;
  localparam logic [ST_W-1:0] FC_FULL = 2'b11;

  localparam logic [ST_W-1:0] HB_BYP  = 2'b00;
  localparam logic [ST_W-1:0] HB_POS  = 2'b01;
  localparam logic [ST_W-1:0] HB_NEG  = 2'b10;

  localparam logic [BAND_W-1:0] BAND_LOW  = 2'b01;
  localparam logic [BAND_W-1:0] BAND_HIGH = 2'b10;

  typedef struct packed {
    logic [ST_W-1:0] fc;
    logic [ST_W-1:0] hb;
  } leg_state_t;
endpackage

// File: rtl/fhs_rst_sync.sv
module fhs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fhs_need_track.sv
module fhs_need_track
  import fhs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [BAND_W-1:0] band,
  output logic              need_chg,
  output logic              out_of_band
);
  logic need_q;
  logic need_d;

  always_comb begin
    out_of_band = (band == BAND_LOW) || (band == BAND_HIGH);
    if (band == BAND_LOW)       need_chg = 1'b1;
    else if (band == BAND_HIGH) need_chg = 1'b0;
    else                        need_chg = need_q;
    need_d = en ? need_chg : need_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) need_q <= 1'b1;
    else        need_q <= need_d;
  end

  // R5
  low_sets_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && band == BAND_LOW |=> need_q);
  // R5
  high_sets_discharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && band == BAND_HIGH |=> !need_q);
  // R5
  in_band_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_band |=> $stable(need_q));
endmodule

// File: rtl/fhs_combo_pick.sv
module fhs_combo_pick
  import fhs_pkg::*;
(
  input  logic [LVL_W-1:0] level,
  input  logic             cur_pos,
  input  logic             fc_need,
  input  logic             fc_oob,
  input  logic             hb_need,
  output leg_state_t       pick,
  output logic             valid
);
  logic [ST_W-1:0] mid_match;
  logic            neg_ok;
  logic            pos_ok;

  always_comb begin
    mid_match = (fc_need == cur_pos) ? FC_MIDA : FC_MIDB;
    neg_ok    = (hb_need == cur_pos);
    pos_ok    = (hb_need != cur_pos);
    valid     = (level < LVL_W'(NUM_LVL));
    pick      = '{fc: FC_ZERO, hb: HB_BYP};
    unique case (level)
      3'd0: pick = '{fc: FC_ZERO, hb: HB_BYP};
      3'd1: begin
        if (neg_ok || fc_oob) pick = '{fc: mid_match, hb: HB_NEG};
        else                  pick = '{fc: FC_ZERO,   hb: HB_POS};
      end
      3'd2: pick = '{fc: mid_match, hb: HB_BYP};
      3'd3: begin
        if (pos_ok || fc_oob) pick = '{fc: mid_match, hb: HB_POS};
        else                  pick = '{fc: FC_FULL,   hb: HB_NEG};
      end
      3'd4: pick = '{fc: FC_FULL, hb: HB_BYP};
      default: pick = '{fc: FC_ZERO, hb: HB_BYP};
    endcase
  end
endmodule

// File: rtl/fhs_balance_sel.sv
module fhs_balance_sel
  import fhs_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [LVL_W-1:0] level_req,
  input  logic             cur_pos,
  input  logic [BAND_W-1:0] fc_band,
  input  logic [BAND_W-1:0] hb_band,
  output logic [ST_W-1:0]  fc_state,
  output logic [ST_W-1:0]  hb_state,
  output logic             level_err
);
  logic       rst_s_n;
  logic       fc_need, fc_oob, hb_need, hb_oob;
  logic       pick_valid;
  leg_state_t pick;
  leg_state_t leg_q, leg_d;
  logic       err_q, err_d;

  fhs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s_n));

  fhs_need_track u_fc_need (
    .clk(clk), .rst_n(rst_s_n), .en(sample_stb), .band(fc_band),
    .need_chg(fc_need), .out_of_band(fc_oob));

  fhs_need_track u_hb_need (
    .clk(clk), .rst_n(rst_s_n), .en(sample_stb), .band(hb_band),
    .need_chg(hb_need), .out_of_band(hb_oob));

  fhs_combo_pick u_pick (
    .level(level_req), .cur_pos(cur_pos), .fc_need(fc_need),
    .fc_oob(fc_oob), .hb_need(hb_need), .pick(pick), .valid(pick_valid));

  always_comb begin
    leg_d = leg_q;
    err_d = err_q;
    if (sample_stb) begin
      err_d = !pick_valid;
      if (pick_valid) leg_d = pick;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      leg_q <= '{fc: FC_ZERO, hb: HB_BYP};
      err_q <= 1'b0;
    end else begin
      leg_q <= leg_d;
      err_q <= err_d;
    end
  end

  assign fc_state  = leg_q.fc;
  assign hb_state  = leg_q.hb;
  assign level_err = err_q;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !sample_stb |=> $stable(leg_q) && $stable(err_q));
  // R3
  level_zero_fixed_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sample_stb && level_req == 3'd0 |=> fc_state == FC_ZERO && hb_state == HB_BYP);
  // R3
  level_top_fixed_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sample_stb && level_req == 3'd4 |=> fc_state == FC_FULL && hb_state == HB_BYP);
  // R4
  bridge_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    hb_state != 2'b11);
  // R6
  mid_level_bypass_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sample_stb && level_req == 3'd2 |=> hb_state == HB_BYP &&
      (fc_state == FC_MIDA || fc_state == FC_MIDB));
  // R10
  bad_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sample_stb && level_req > 3'd4 |=> level_err && $stable(leg_q));
  // R10
  good_level_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    sample_stb && level_req <= 3'd4 |=> !level_err);
endmodule

// File: tb/fhs_balance_sel_tb.sv
`timescale 1ns/1ps
module fhs_balance_sel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_stb;
  logic [2:0] level_req;
  logic       cur_pos;
  logic [1:0] fc_band, hb_band;
  logic [1:0] fc_state, hb_state;
  logic       level_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // model state
  bit       m_fneed, m_hneed, m_err;
  bit [1:0] m_fc, m_hb;
  string    m_tag;

  always #2.5 clk = ~clk;

  fhs_balance_sel dut_i (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .level_req(level_req),
    .cur_pos(cur_pos), .fc_band(fc_band), .hb_band(hb_band),
    .fc_state(fc_state), .hb_state(hb_state), .level_err(level_err));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fc_contrib(input int s);
    return (s == 0) ? 0 : (s == 3) ? 4 : 2;
  endfunction
  function automatic int hb_contrib(input int s);
    return (s == 1) ? 1 : (s == 2) ? -1 : 0;
  endfunction

  // Score every legal pair for the level and keep the best one.
  task automatic model_pick(input int lvl, input bit dir, input bit foob);
    int best = -1;
    int bfs = 0, bhs = 0;
    for (int f = 0; f < 4; f++) begin
      for (int h = 0; h < 3; h++) begin
        if (fc_contrib(f) + hb_contrib(h) == lvl) begin
          int fe, he, fs, hs, sc;
          fe = (f == 1) ? (dir ? 1 : -1) : (f == 2) ? (dir ? -1 : 1) : 0;
          he = (h == 1) ? (dir ? -1 : 1) : (h == 2) ? (dir ? 1 : -1) : 0;
          fs = (fe == 0) ? 1 : (((fe > 0) == m_fneed) ? 2 : 0);
          hs = (he == 0) ? 1 : (((he > 0) == m_hneed) ? 2 : 0);
          sc = foob ? 3 * fs + hs : fs + hs;
          if (sc > best) begin
            best = sc; m_fc = 2'(f); m_hb = 2'(h); bfs = fs; bhs = hs;
          end
        end
      end
    end
    if (lvl == 0 || lvl == 4)      m_tag = "R3";
    else if (lvl == 2)             m_tag = "R6";
    else if (bfs == 2 && bhs == 2) m_tag = "R7";
    else if (foob)                 m_tag = "R8";
    else                           m_tag = "R9";
  endtask

  task automatic sample(input int lvl, input bit dir, input bit [1:0] fb, input bit [1:0] hbb);
    bit foob;
    @(negedge clk);
    level_req = 3'(lvl); cur_pos = dir; fc_band = fb; hb_band = hbb;
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    if (fb == 2'b01) m_fneed = 1; else if (fb == 2'b10) m_fneed = 0;
    if (hbb == 2'b01) m_hneed = 1; else if (hbb == 2'b10) m_hneed = 0;
    foob = (fb == 2'b01) || (fb == 2'b10);
    if (lvl <= 4) begin
      model_pick(lvl, dir, foob);
      m_err = 0;
      check({m_tag, " state"}, {fc_state, hb_state}, {m_fc, m_hb});
      check("R4 level sum", fc_contrib(fc_state) + hb_contrib(hb_state), lvl);
      check("R10 err clear", level_err, 0);
    end else begin
      m_err = 1;
      check("R10 hold", {fc_state, hb_state}, {m_fc, m_hb});
      check("R10 err set", level_err, 1);
    end
  endtask

  // Change inputs with strobe low; outputs must not move (R2).
  task automatic idle_probe(input int lvl, input bit dir);
    @(negedge clk);
    level_req = 3'(lvl); cur_pos = dir; fc_band = 2'b10; hb_band = 2'b01;
    @(negedge clk);
    @(negedge clk);
    check("R2 idle hold", {fc_state, hb_state, level_err}, {m_fc, m_hb, m_err});
  endtask

  initial begin
    rst_n = 1'b0; sample_stb = 1'b0; level_req = 3'd2; cur_pos = 1'b1;
    fc_band = 2'b00; hb_band = 2'b00;
    m_fneed = 1; m_hneed = 1; m_err = 0; m_fc = 0; m_hb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    check("R1 reset", {fc_state, hb_state, level_err}, 5'b0);
    // R1 needs reset to charge: level 2, in band, cur_pos=1 -> mid 01
    sample(2, 1, 2'b00, 2'b00);
    check("R1 need reset charge", fc_state, 1);

    // R5 directed walk at level 2
    sample(2, 1, 2'b10, 2'b00);
    check("R5 above->discharge", fc_state, 2);
    sample(2, 1, 2'b00, 2'b00);
    check("R5 in band holds", fc_state, 2);
    sample(2, 1, 2'b11, 2'b00);
    check("R5 code 11 holds", fc_state, 2);
    sample(2, 1, 2'b01, 2'b00);
    check("R5 below->charge", fc_state, 1);
    idle_probe(4, 0);

    // exhaustive sweep
    for (int l = 0; l < 8; l++)
      for (int d = 0; d < 2; d++)
        for (int f = 0; f < 4; f++)
          for (int h = 0; h < 4; h++) begin
            sample(l, d[0], 2'(f), 2'(h));
            if (h == 3 && f == 3) idle_probe((l + 3) % 8, !d[0]);
          end

    // R10 invalid then valid
    sample(6, 0, 2'b00, 2'b00);
    idle_probe(1, 1);
    sample(4, 0, 2'b01, 2'b10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule